// File: doc/BRIEF.md
# Frame launch control register

This block is the software-facing control and status register set for a streaming frame engine. A simple register bus (write strobe, read strobe, byte address, write data) reaches it on one side. On the other side it drives a start request to the engine and watches the engine's done, idle and ready handshake lines. Software launches a single frame by writing the start bit. As an alternative, it sets an auto-relaunch bit, and the block then keeps the engine running frame after frame with no further writes.

Frame completion is caught in a sticky done flag. The flag clears when software reads the control word. If completion coincides with that read, the completion wins, so no frame end is ever lost. Three further words hold an interrupt master enable, two per-channel enables and two per-channel status bits. These words are plain storage. They do not drive any output.

Read data is registered. It appears on the bus one cycle after the read strobe and is held until the next read. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `frame_ctrl_csr`

## Requirements
- R1: After reset, eng_start is 0, bus_rdata is 0, and reading offsets 0x00, 0x04, 0x08 and 0x0C returns 0.
- R2: A write to offset 0x00 with bit 0 set drives eng_start to 1 from the next cycle. A write to offset 0x00 with bit 0 clear does not drop an active start.
- R3: With bit 7 of the control word at 0, one cycle of eng_ready while eng_start is 1 drops eng_start in the following cycle.
- R4: Bit 7 of offset 0x00 is the auto-relaunch flag and reads back as written. While it is 1, eng_ready does not drop eng_start, so the engine is relaunched on the cycle after ready.
- R5: A one-cycle eng_done pulse sets the done flag, which reads as bit 1 of offset 0x00 and stays set until it is cleared.
- R6: A read of offset 0x00 returns the done flag's value from before the read, then clears the flag.
- R7: When an eng_done pulse falls in the same cycle as a read of offset 0x00, the flag is set afterwards.
- R8: Bits 2 (idle) and 3 (ready) of offset 0x00 show eng_idle and eng_ready as sampled in the read cycle. Writes to offset 0x00 cannot change bits 1 to 6, and the other bits read 0.
- R9: Offset 0x04 stores bit 0, and offsets 0x08 and 0x0C each store bits 1:0. All three read back as written, with 0 in every other bit. Writing them has no effect on eng_start.
- R10: Reads of any other offset, including unaligned ones, return 0. Writes there change no register.
- R11: bus_rdata updates only on the cycle after a read strobe and holds its value otherwise.
- R12: A start write in the same cycle as eng_ready leaves eng_start at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after bus_rd_en |
| eng_start | output | 1 | Start request to the frame engine |
| eng_done | input | 1 | Frame completion pulse from the engine |
| eng_idle | input | 1 | Engine idle level |
| eng_ready | input | 1 | Engine accepted the start, one-cycle pulse |

## Verification
A wrong start flag is visible on eng_start one cycle after the write or handshake that moved it. The checks therefore sample it right after each write and each ready pulse, including the ready-and-write collision. A corrupted done flag or a lost set/clear race only shows on the next control read, one cycle after that strobe. For that reason every completion is followed by two back-to-back reads, which expose both the captured value and the clear. Storage or decode faults show as wrong data on the read that follows the write, so every mapped and unmapped offset is read back after being written.

// File: rtl/frame_csr_pkg.sv
`timescale 1ns/1ps
package frame_csr_pkg;

  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_GIE  = 32'h04;
  localparam int unsigned OFF_IER  = 32'h08;
  localparam int unsigned OFF_ISR  = 32'h0C;

  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_DONE  = 1;
  localparam int unsigned BIT_IDLE  = 2;
  localparam int unsigned BIT_READY = 3;
  localparam int unsigned BIT_AUTO  = 7;

  localparam int unsigned NUM_AUX = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_GIE,
    SEL_IER,
    SEL_ISR
  } csr_sel_e;

  function automatic int unsigned aux_width(input int unsigned idx);
    return (idx == 0) ? 1 : 2;
  endfunction

  function automatic csr_sel_e aux_sel(input int unsigned idx);
    case (idx)
      0:       return SEL_GIE;
      1:       return SEL_IER;
      default: return SEL_ISR;
    endcase
  endfunction

endpackage

// File: rtl/frame_csr_decode.sv
`timescale 1ns/1ps
module frame_csr_decode
  import frame_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFF_CTRL))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_GIE))  sel = SEL_GIE;
    else if (addr == ADDR_W'(OFF_IER))  sel = SEL_IER;
    else if (addr == ADDR_W'(OFF_ISR))  sel = SEL_ISR;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/frame_csr_auxreg.sv
`timescale 1ns/1ps
module frame_csr_auxreg #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  always_comb begin
    q_d = wr_en ? wdata : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (wr_en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/frame_csr_launch.sv
`timescale 1ns/1ps
module frame_csr_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_start,
  input  logic wr_auto,
  input  logic eng_ready,
  output logic start_o,
  output logic auto_o
);

  logic start_q, start_d;
  logic auto_q, auto_d;
  logic set_req;
  logic handshake;
  logic upd_en;

  assign set_req   = ctrl_wr & wr_start;
  assign handshake = start_q & eng_ready;
  assign upd_en    = ctrl_wr | handshake;

  always_comb begin
    auto_d = ctrl_wr ? wr_auto : auto_q;
    if (set_req)        start_d = 1'b1;
    else if (handshake) start_d = auto_q;
    else                start_d = start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
    end else if (upd_en) begin
      start_q <= start_d;
      auto_q  <= auto_d;
    end
  end

  assign start_o = start_q;
  assign auto_o  = auto_q;

  p_set_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> start_q);

  p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && eng_ready && !auto_q && !set_req) |=> !start_q);

  p_auto_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && eng_ready && auto_q) |=> start_q);

  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && eng_ready) |=> start_q);

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !eng_ready) |=> $stable(start_q));

endmodule

// File: rtl/frame_csr_done.sv
`timescale 1ns/1ps
module frame_csr_done (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_done,
  input  logic clr,
  output logic done_o
);

  logic done_q, done_d;
  logic upd_en;

  assign upd_en = eng_done | clr;

  always_comb begin
    if (eng_done)  done_d = 1'b1;
    else if (clr)  done_d = 1'b0;
    else           done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (upd_en) begin
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !eng_done) |=> !done_q);

  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && eng_done) |=> done_q);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q);

endmodule

// File: rtl/frame_ctrl_csr.sv
`timescale 1ns/1ps
module frame_ctrl_csr
  import frame_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic              eng_idle,
  input  logic              eng_ready
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  csr_sel_e sel;

  frame_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  logic ctrl_wr;
  logic ctrl_rd;

  assign ctrl_wr = bus_wr_en & (sel == SEL_CTRL);
  assign ctrl_rd = bus_rd_en & (sel == SEL_CTRL);

  // launch control
  logic start_flag;
  logic auto_flag;

  frame_csr_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_wr   (ctrl_wr),
    .wr_start  (bus_wdata[BIT_START]),
    .wr_auto   (bus_wdata[BIT_AUTO]),
    .eng_ready (eng_ready),
    .start_o   (start_flag),
    .auto_o    (auto_flag)
  );

  assign eng_start = start_flag;

  // sticky completion flag
  logic done_flag;

  frame_csr_done u_done (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .eng_done (eng_done),
    .clr      (ctrl_rd),
    .done_o   (done_flag)
  );

  // storage-only words
  logic [DATA_W-1:0] aux_word [NUM_AUX];

  for (genvar gi = 0; gi < NUM_AUX; gi++) begin : g_aux
    localparam int unsigned W = aux_width(gi);
    logic         wr;
    logic [W-1:0] q;

    assign wr = bus_wr_en & (sel == aux_sel(gi));

    frame_csr_auxreg #(.W(W)) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (wr),
      .wdata (bus_wdata[W-1:0]),
      .q     (q)
    );

    assign aux_word[gi] = {{(DATA_W-W){1'b0}}, q};
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:BIT_AUTO+1], bus_wdata[BIT_AUTO-1:BIT_START+2]};

  // read path
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_START] = start_flag;
    ctrl_word[BIT_DONE]  = done_flag;
    ctrl_word[BIT_IDLE]  = eng_idle;
    ctrl_word[BIT_READY] = eng_ready;
    ctrl_word[BIT_AUTO]  = auto_flag;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_GIE:  rd_mux = aux_word[0];
      SEL_IER:  rd_mux = aux_word[1];
      SEL_ISR:  rd_mux = aux_word[2];
      default:  rd_mux = '0;
    endcase
    rdata_d = bus_rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (bus_rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd_en && sel == SEL_NONE) |=> (bus_rdata == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd_en |=> $stable(bus_rdata));

  p_live_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_rd |=> (bus_rdata[BIT_IDLE] == $past(eng_idle)));

  p_gie_reserved_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd_en && sel == SEL_GIE) |=> (bus_rdata[DATA_W-1:1] == '0));

endmodule

// File: tb/frame_ctrl_csr_bench.sv
`timescale 1ns/1ps
module frame_ctrl_csr_bench;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          eng_start;
  logic          eng_done = 1'b0;
  logic          eng_idle = 1'b0;
  logic          eng_ready = 1'b0;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;

  always #5 clk = ~clk;

  frame_ctrl_csr #(.ADDR_W(AW), .DATA_W(DW)) u_frame_ctrl_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_idle  (eng_idle),
    .eng_ready (eng_ready)
  );

  // monitor: compares each registered read against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (bus_rdata !== e)
          begin
            fails++;
            $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
          end
      end
    end
  end

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd_en = 1'b1;
    bus_addr  = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ready();
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(DW'(eng_start), 0, "R1 start after reset");
    chk(bus_rdata, 0, "R1 rdata after reset");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 gie");
    rd(8'h08, 32'h0, "R1 ier");
    rd(8'h0C, 32'h0, "R1 isr");

    // R8 live idle/ready, no effect while start low
    eng_idle  = 1'b1;
    eng_ready = 1'b1;
    rd(8'h00, 32'h0000_000C, "R8 live bits");
    eng_ready = 1'b0;
    eng_idle  = 1'b0;
    chk(DW'(eng_start), 0, "R8 ready alone");
    wr(8'h00, 32'h0000_007E);
    rd(8'h00, 32'h0, "R8 status bits not writable");

    // R2 start write, zero write keeps it
    wr(8'h00, 32'h1);
    chk(DW'(eng_start), 1, "R2 start set");
    wr(8'h00, 32'h0);
    chk(DW'(eng_start), 1, "R2 zero write keeps start");
    rd(8'h00, 32'h1, "R2 start readback");

    // R3 handshake clears
    pulse_ready();
    chk(DW'(eng_start), 0, "R3 start dropped on ready");

    // R5 / R6 sticky done and clear on read
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h00, 32'h2, "R5 done sticky");
    rd(8'h00, 32'h0, "R6 done cleared by read");

    // R7 done coincides with read
    eng_done = 1'b1;
    bus_rd_en = 1'b1;
    bus_addr  = 8'h00;
    exp_q.push_back(32'h0);
    tag_q.push_back("R7 coincident read value");
    @(negedge clk);
    eng_done  = 1'b0;
    bus_rd_en = 1'b0;
    @(negedge clk);
    rd(8'h00, 32'h2, "R7 set wins over clear");
    rd(8'h00, 32'h0, "R6 cleared after");

    // R4 auto relaunch
    wr(8'h00, 32'h81);
    chk(DW'(eng_start), 1, "R4 start with auto");
    pulse_ready();
    chk(DW'(eng_start), 1, "R4 relaunch after ready");
    rd(8'h00, 32'h81, "R4 auto readback");
    pulse_ready();
    chk(DW'(eng_start), 1, "R4 second relaunch");
    wr(8'h00, 32'h0);
    chk(DW'(eng_start), 1, "R4 auto off keeps start");
    pulse_ready();
    chk(DW'(eng_start), 0, "R3 drop once auto off");
    rd(8'h00, 32'h0, "R4 auto cleared");

    // R12 write and ready collide
    wr(8'h00, 32'h1);
    eng_ready = 1'b1;
    wr(8'h00, 32'h1);
    eng_ready = 1'b0;
    chk(DW'(eng_start), 1, "R12 write wins");
    pulse_ready();
    chk(DW'(eng_start), 0, "R3 drop after collision");

    // R9 storage words
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFE);
    chk(DW'(eng_start), 0, "R9 storage has no effect");
    rd(8'h04, 32'h1, "R9 gie");
    rd(8'h0C, 32'h2, "R9 isr");
    rd(8'h08, 32'h3, "R9 ier");

    // R11 hold between reads
    repeat (3) @(negedge clk);
    chk(bus_rdata, 32'h3, "R11 rdata held");

    // R10 unmapped
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R10 unmapped 0x10");
    rd(8'h05, 32'h0, "R10 unaligned 0x05");
    rd(8'h00, 32'h0, "R10 ctrl untouched");
    chk(DW'(eng_start), 0, "R10 start untouched");
    rd(8'h04, 32'h1, "R10 gie untouched");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finished = 1'b1;
    summary();
  end

endmodule